// File: doc/BRIEF.md
# Indirect-Access GPIO Pin Bank

This block is a bank of 22 general-purpose pins split into three groups of eight, six and eight pins. The host reaches the pin data through an index/data port pair on its I/O bus. It writes a group number to the index port, then reads or writes that group's 8-bit data register through the data port. A selection register, written over a separate configuration bus, turns the port pair on and chooses which of four address pairs the host must use.

The configuration bus also writes one byte per pin. That byte sets the pin's direction and output polarity, and it can hand the pin over to an alternate function. The block drives the pad output and output-enable signals. It samples the pad inputs through a synchronizer. For a pin in special mode, it routes the alternate-function output and enable straight to the pad. Turning the bank on returns every pin to a plain, non-inverted input.

Top module: `ibgpio_bank`

## Requirements
- R1: After reset, every output enable is 0, every pin output is 0 and the bank is disabled.
- R2: On the configuration bus, address 0x03 is the port-select register. Bit 7 enables the bank. Bits 1:0 place the index/data ports at 0xE0/0xE1 (0), 0xE2/0xE3 (1), 0xE4/0xE5 (2) or 0xEA/0xEB (3). Host accesses to the other pairs are ignored and read 0.
- R3: While the bank is disabled, host writes to any port pair are ignored, every read returns 0, and all output enables are 0.
- R4: Index value 1 selects the data of pins 0-7, 2 selects pins 8-13 and 3 selects pins 14-21, where data bit b maps to the group's b-th pin. A read of the index port returns the stored index. For any other index value, data reads return 0 and data writes are ignored.
- R5: In the data register of the second group (pins 8-13), bits 7 and 6 always read 0 and writing them has no effect.
- R6: Pin configuration bytes are written at configuration addresses 0xE0-0xE7 (pins 0-7), 0xE8-0xED (pins 8-13) and 0xF5-0xFC (pins 14-21). Writes to other addresses, such as 0xEE, 0xF4 or 0xFD, change no pin.
- R7: In a configuration byte, bit 0 = 1 makes the pin an input (output enable 0). With bit 0 = 0 the pin drives its output latch XOR bit 1 (the invert bit) with its output enable at 1.
- R8: A data read returns, for each pin, the synchronized pad input XOR the invert bit when the pin is an input or in special mode, and the output latch when the pin is an output. A pad change becomes visible two clock edges later.
- R9: Bit 3 = 1 in a configuration byte selects special mode. The pad output and output enable then follow the alternate-function inputs for that pin, and the output latch has no effect on the pad.
- R10: A port-select write that sets bit 7 while the bank is disabled resets every pin configuration to a non-inverted normal input. Rewriting the register while the bank is already enabled keeps the pin configurations.
- R11: Data writes always update the output latches, including those of input and special pins. A stored value is driven once the pin becomes a normal output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| io_addr_i | input | 16 | Host I/O address |
| io_wr_i | input | 1 | Host write strobe |
| io_rd_i | input | 1 | Host read strobe |
| io_wdata_i | input | 8 | Host write data |
| io_rdata_o | output | 8 | Host read data, valid while io_rd_i is high, else 0 |
| gpio_i | input | 22 | Pad input levels |
| gpio_o | output | 22 | Pad output levels |
| gpio_oe_o | output | 22 | Pad output enables |
| alt_o_i | input | 22 | Alternate-function output per pin |
| alt_oe_i | input | 22 | Alternate-function output enable per pin |

## Verification
The bench moves the port pair among address pairs and checks that the old pair goes silent. A decoder that ignores the selection bits would still answer at 0xE0/0xE1. The bench writes data to pins that are inputs or in special mode, then switches them to outputs. A design that drops those writes, or that lets the latch leak into a special pin, shows the wrong pad level. The bench also checks that an inverted output reads back its latch value while an inverted input reads back the flipped pad value. Finally, it switches the bank off and on and confirms that the pin configurations reset only on the enabling write and not on a rewrite while the bank is already on. A design that resets on every write, or never, drives outputs that should be inputs.

// File: rtl/ibgpio_pkg.sv
package ibgpio_pkg;

  typedef struct packed {
    logic spc;   // alternate function owns the pad
    logic inv;   // polarity invert
    logic is_in; // direction: 1 = input
  } pin_cfg_t;

  localparam pin_cfg_t PIN_CFG_RST = '{spc: 1'b0, inv: 1'b0, is_in: 1'b1};

  function automatic int pin_grp(int p, int w0, int w1);
    if (p < w0) return 0;
    if (p < w0 + w1) return 1;
    return 2;
  endfunction

  function automatic int pin_bit(int p, int w0, int w1);
    if (p < w0) return p;
    if (p < w0 + w1) return p - w0;
    return p - w0 - w1;
  endfunction

  // index-port address for each pair selection
  function automatic logic [7:0] pair_base(logic [1:0] sel);
    case (sel)
      2'd0:    return 8'hE0;
      2'd1:    return 8'hE2;
      2'd2:    return 8'hE4;
      default: return 8'hEA;
    endcase
  endfunction

endpackage

// File: rtl/ibgpio_cfg.sv
module ibgpio_cfg
  import ibgpio_pkg::*;
#(
  parameter int G0_W     = 8,
  parameter int G1_W     = 6,
  parameter int G2_W     = 8,
  parameter int G0_BASE  = 'hE0,
  parameter int G1_BASE  = 'hE8,
  parameter int G2_BASE  = 'hF5,
  parameter int SEL_ADDR = 'h03,
  localparam int PIN_N   = G0_W + G1_W + G2_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [7:0]           cfg_addr_i,
  input  logic [7:0]           cfg_wdata_i,
  output logic                 en_o,
  output logic [1:0]           pair_o,
  output pin_cfg_t [PIN_N-1:0] cfg_o
);

  logic       sel_we;
  logic       en_rise;
  logic [4:0] unused_wdata;

  assign sel_we       = cfg_we_i && (cfg_addr_i == 8'(SEL_ADDR));
  assign en_rise      = sel_we && cfg_wdata_i[7] && !en_o;
  assign unused_wdata = {cfg_wdata_i[6:4], cfg_wdata_i[2], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      pair_o <= 2'd0;
    end else if (sel_we) begin
      en_o   <= cfg_wdata_i[7];
      pair_o <= cfg_wdata_i[1:0];
    end
  end

  for (genvar p = 0; p < PIN_N; p++) begin : g_pin
    localparam int ADDR = (p < G0_W)        ? G0_BASE + p :
                          (p < G0_W + G1_W) ? G1_BASE + p - G0_W :
                                              G2_BASE + p - G0_W - G1_W;
    logic hit;
    assign hit = cfg_we_i && (cfg_addr_i == 8'(ADDR));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[p] <= PIN_CFG_RST;
      end else if (en_rise) begin
        cfg_o[p] <= PIN_CFG_RST;
      end else if (hit) begin
        cfg_o[p] <= '{spc: cfg_wdata_i[3], inv: cfg_wdata_i[1], is_in: cfg_wdata_i[0]};
      end
    end
  end

endmodule

// File: rtl/ibgpio_host.sv
module ibgpio_host
  import ibgpio_pkg::*;
#(
  parameter int IO_AW  = 16,
  parameter int G0_W   = 8,
  parameter int G1_W   = 6,
  parameter int G2_W   = 8,
  localparam int PIN_N = G0_W + G1_W + G2_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       pair_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic             io_wr_i,
  input  logic             io_rd_i,
  input  logic [7:0]       io_wdata_i,
  output logic [7:0]       io_rdata_o,
  input  logic [PIN_N-1:0] rd_bits_i,
  output logic [PIN_N-1:0] lat_we_o,
  output logic [PIN_N-1:0] lat_d_o,
  output logic [7:0]       idx_o
);

  logic [IO_AW-1:0] idx_addr;
  logic [IO_AW-1:0] dat_addr;
  logic             idx_hit;
  logic             dat_hit;
  logic [2:0][7:0]  grp_rd;

  assign idx_addr = IO_AW'(pair_base(pair_i));
  assign dat_addr = idx_addr + IO_AW'(1);
  assign idx_hit  = en_i && (io_addr_i == idx_addr);
  assign dat_hit  = en_i && (io_addr_i == dat_addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_o <= 8'd0;
    else if (idx_hit && io_wr_i) idx_o <= io_wdata_i;
  end

  always_comb begin
    grp_rd = '0;
    for (int p = 0; p < PIN_N; p++) begin
      grp_rd[pin_grp(p, G0_W, G1_W)][pin_bit(p, G0_W, G1_W)] = rd_bits_i[p];
    end
  end

  always_comb begin
    for (int p = 0; p < PIN_N; p++) begin
      lat_we_o[p] = dat_hit && io_wr_i && (idx_o == 8'(pin_grp(p, G0_W, G1_W) + 1));
      lat_d_o[p]  = io_wdata_i[pin_bit(p, G0_W, G1_W)];
    end
  end

  always_comb begin
    io_rdata_o = 8'd0;
    if (io_rd_i && idx_hit) begin
      io_rdata_o = idx_o;
    end else if (io_rd_i && dat_hit) begin
      case (idx_o)
        8'd1:    io_rdata_o = grp_rd[0];
        8'd2:    io_rdata_o = grp_rd[1];
        8'd3:    io_rdata_o = grp_rd[2];
        default: io_rdata_o = 8'd0;
      endcase
    end
  end

endmodule

// File: rtl/ibgpio_pin.sv
module ibgpio_pin
  import ibgpio_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  pin_cfg_t cfg_i,
  input  logic     lat_we_i,
  input  logic     lat_d_i,
  input  logic     pad_i,
  input  logic     alt_o_i,
  input  logic     alt_oe_i,
  output logic     pad_o,
  output logic     pad_oe_o,
  output logic     rd_o
);

  logic lat_q;
  logic pad_s;

  if (SYNC_N <= 1) begin : g_sync1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pad_s <= 1'b0;
      else         pad_s <= pad_i;
    end
  end else begin : g_syncn
    logic [SYNC_N-1:0] sq;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sq <= '0;
      else         sq <= {sq[SYNC_N-2:0], pad_i};
    end
    assign pad_s = sq[SYNC_N-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lat_q <= 1'b0;
    else if (lat_we_i) lat_q <= lat_d_i;
  end

  always_comb begin
    if (cfg_i.spc) begin
      pad_o    = alt_o_i;
      pad_oe_o = alt_oe_i && en_i;
    end else begin
      pad_o    = lat_q ^ cfg_i.inv;
      pad_oe_o = !cfg_i.is_in && en_i;
    end
  end

  assign rd_o = (cfg_i.spc || cfg_i.is_in) ? (pad_s ^ cfg_i.inv) : lat_q;

endmodule

// File: rtl/ibgpio_bank.sv
module ibgpio_bank
  import ibgpio_pkg::*;
#(
  parameter int IO_AW    = 16,
  parameter int G0_W     = 8,
  parameter int G1_W     = 6,
  parameter int G2_W     = 8,
  parameter int SYNC_N   = 2,
  parameter int SEL_ADDR = 'h03,
  localparam int PIN_N   = G0_W + G1_W + G2_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_addr_i,
  input  logic [7:0]       cfg_wdata_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic             io_wr_i,
  input  logic             io_rd_i,
  input  logic [7:0]       io_wdata_i,
  output logic [7:0]       io_rdata_o,
  input  logic [PIN_N-1:0] gpio_i,
  output logic [PIN_N-1:0] gpio_o,
  output logic [PIN_N-1:0] gpio_oe_o,
  input  logic [PIN_N-1:0] alt_o_i,
  input  logic [PIN_N-1:0] alt_oe_i
);

  logic                 bank_en;
  logic [1:0]           pair_sel;
  pin_cfg_t [PIN_N-1:0] pin_cfg;
  logic [PIN_N-1:0]     rd_bits;
  logic [PIN_N-1:0]     lat_we;
  logic [PIN_N-1:0]     lat_d;
  logic [7:0]           host_idx;
  logic [PIN_N-1:0]     cfg_in_v;
  logic [PIN_N-1:0]     cfg_spc_v;

  ibgpio_cfg #(
    .G0_W(G0_W), .G1_W(G1_W), .G2_W(G2_W), .SEL_ADDR(SEL_ADDR)
  ) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .en_o(bank_en), .pair_o(pair_sel), .cfg_o(pin_cfg)
  );

  ibgpio_host #(
    .IO_AW(IO_AW), .G0_W(G0_W), .G1_W(G1_W), .G2_W(G2_W)
  ) u_host (
    .clk_i, .rst_ni, .en_i(bank_en), .pair_i(pair_sel),
    .io_addr_i, .io_wr_i, .io_rd_i, .io_wdata_i, .io_rdata_o,
    .rd_bits_i(rd_bits), .lat_we_o(lat_we), .lat_d_o(lat_d), .idx_o(host_idx)
  );

  for (genvar p = 0; p < PIN_N; p++) begin : g_pin
    ibgpio_pin #(.SYNC_N(SYNC_N)) u_pin (
      .clk_i, .rst_ni, .en_i(bank_en), .cfg_i(pin_cfg[p]),
      .lat_we_i(lat_we[p]), .lat_d_i(lat_d[p]), .pad_i(gpio_i[p]),
      .alt_o_i(alt_o_i[p]), .alt_oe_i(alt_oe_i[p]),
      .pad_o(gpio_o[p]), .pad_oe_o(gpio_oe_o[p]), .rd_o(rd_bits[p])
    );
    assign cfg_in_v[p]  = pin_cfg[p].is_in;
    assign cfg_spc_v[p] = pin_cfg[p].spc;
  end

endmodule

// File: rtl/ibgpio_chk.sv
module ibgpio_chk #(
  parameter int G1_W     = 6,
  parameter int PIN_N    = 22,
  parameter int SEL_ADDR = 'h03
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [7:0]       cfg_addr_i,
  input logic [7:0]       cfg_wdata_i,
  input logic             io_rd_i,
  input logic [7:0]       io_rdata_o,
  input logic [PIN_N-1:0] gpio_oe_o,
  input logic             bank_en,
  input logic [7:0]       host_idx,
  input logic [PIN_N-1:0] cfg_in_v,
  input logic [PIN_N-1:0] cfg_spc_v
);

  a_r3_off_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_en |-> (gpio_oe_o == '0));

  a_r3_off_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_en |-> (io_rdata_o == 8'd0));

  a_r7_input_not_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpio_oe_o & cfg_in_v & ~cfg_spc_v) == '0);

  a_r10_enable_inits_inputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == 8'(SEL_ADDR) && cfg_wdata_i[7] && !bank_en)
      |=> (&cfg_in_v && !(|cfg_spc_v)));

  a_r5_grp2_high_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && host_idx == 8'd2) |-> ((io_rdata_o >> G1_W) == 8'd0));

endmodule

bind ibgpio_bank ibgpio_chk #(.G1_W(G1_W), .PIN_N(PIN_N), .SEL_ADDR(SEL_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i), .io_rd_i(io_rd_i), .io_rdata_o(io_rdata_o),
  .gpio_oe_o(gpio_oe_o), .bank_en(bank_en), .host_idx(host_idx),
  .cfg_in_v(cfg_in_v), .cfg_spc_v(cfg_spc_v)
);

// File: tb/tb_ibgpio_bank.sv
module tb_ibgpio_bank;

  localparam int CLK_PERIOD = 10;
  localparam int PIN_N = 22;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [7:0]       cfg_addr_i = '0;
  logic [7:0]       cfg_wdata_i = '0;
  logic [15:0]      io_addr_i = '0;
  logic             io_wr_i = 1'b0;
  logic             io_rd_i = 1'b0;
  logic [7:0]       io_wdata_i = '0;
  logic [7:0]       io_rdata_o;
  logic [PIN_N-1:0] gpio_i = '0;
  logic [PIN_N-1:0] gpio_o;
  logic [PIN_N-1:0] gpio_oe_o;
  logic [PIN_N-1:0] alt_o_i = '0;
  logic [PIN_N-1:0] alt_oe_i = '0;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ibgpio_bank dut (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk_i);
    #(CLK_PERIOD/4);
  endtask

  task automatic cfg_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic io_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk_i);
    io_wr_i = 1'b1; io_addr_i = a; io_wdata_i = d;
    @(negedge clk_i);
    io_wr_i = 1'b0;
  endtask

  // driver: queue expectation, monitor compares during the strobe
  task automatic io_rd(logic [15:0] a, logic [7:0] exp, string tag);
    @(negedge clk_i);
    io_rd_i = 1'b1; io_addr_i = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk_i);
    io_rd_i = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk_i);
      #(CLK_PERIOD/4);
      if (io_rd_i && exp_q.size() > 0) begin
        chk(tag_q.pop_front(), 32'(io_rdata_o), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin : stim
    gpio_i[7:0]  = 8'h3C;
    gpio_i[13:8] = 6'b101100;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    settle();
    chk("R1 oe after reset", 32'(gpio_oe_o), 32'h0);
    chk("R1 out after reset", 32'(gpio_o), 32'h0);

    // disabled: writes ignored, reads zero
    io_wr(16'hE0, 8'h01);
    io_wr(16'hE1, 8'h5A);
    io_rd(16'hE1, 8'h00, "R3 read while disabled");

    cfg_wr(8'h03, 8'h80);
    settle();
    chk("R10 enable leaves inputs", 32'(gpio_oe_o), 32'h0);

    for (int p = 0; p < 8; p++) cfg_wr(8'(8'hE0 + p), 8'h00);
    settle();
    chk("R6 R7 group1 outputs enabled", 32'(gpio_oe_o), 32'h0000FF);
    chk("R3 disabled write dropped", 32'(gpio_o[7:0]), 32'h00);

    io_wr(16'hE0, 8'h01);
    io_wr(16'hE1, 8'hA5);
    settle();
    chk("R4 index1 drives pins 0-7", 32'(gpio_o[7:0]), 32'hA5);
    io_rd(16'hE1, 8'hA5, "R8 output readback");

    cfg_wr(8'hE0, 8'h02);
    settle();
    chk("R7 inverted output", 32'(gpio_o[0]), 32'h0);
    io_rd(16'hE1, 8'hA5, "R8 inverted output reads latch");

    cfg_wr(8'hE9, 8'h03);
    repeat (3) @(negedge clk_i);
    io_wr(16'hE0, 8'h02);
    io_rd(16'hE1, 8'h2E, "R8 R5 group2 input read");
    io_rd(16'hE0, 8'h02, "R4 index readback");

    io_wr(16'hE1, 8'hFF);
    settle();
    chk("R11 input pins not driven", 32'(gpio_oe_o[13:8]), 32'h0);
    cfg_wr(8'hE8, 8'h00);
    settle();
    chk("R11 stored bit driven", 32'(gpio_o[8]), 32'h1);
    chk("R11 pin8 enabled", 32'(gpio_oe_o[8]), 32'h1);
    io_rd(16'hE1, 8'h2F, "R5 bits 7:6 read zero");

    cfg_wr(8'hF5, 8'h00);
    cfg_wr(8'hEE, 8'h00);
    cfg_wr(8'hF4, 8'h00);
    cfg_wr(8'hFD, 8'h00);
    settle();
    chk("R6 group3 base and holes", 32'(gpio_oe_o[21:8]), 32'h0041);

    alt_o_i[15] = 1'b1; alt_oe_i[15] = 1'b1;
    cfg_wr(8'hF6, 8'h08);
    settle();
    chk("R9 special oe", 32'(gpio_oe_o[15]), 32'h1);
    chk("R9 special out", 32'(gpio_o[15]), 32'h1);
    alt_oe_i[15] = 1'b0;
    settle();
    chk("R9 special oe follows alt", 32'(gpio_oe_o[15]), 32'h0);
    io_wr(16'hE0, 8'h03);
    io_wr(16'hE1, 8'h02);
    alt_o_i[15] = 1'b0;
    settle();
    chk("R4 group3 bit0 write", 32'(gpio_o[14]), 32'h0);
    chk("R9 latch does not reach special pin", 32'(gpio_o[15]), 32'h0);
    cfg_wr(8'hF6, 8'h00);
    settle();
    chk("R11 latch after leaving special", 32'({gpio_oe_o[15], gpio_o[15]}), 32'h3);

    cfg_wr(8'h03, 8'h83);
    io_rd(16'hE1, 8'h00, "R2 old pair silent");
    io_wr(16'hEA, 8'h01);
    io_rd(16'hEB, 8'hA5, "R2 pair 3 data");
    settle();
    chk("R10 rewrite keeps configs", 32'(gpio_oe_o[7:0]), 32'hFF);

    io_wr(16'hEA, 8'h05);
    io_rd(16'hEB, 8'h00, "R4 bad index reads zero");
    io_wr(16'hEB, 8'h00);
    io_wr(16'hEA, 8'h01);
    io_rd(16'hEB, 8'hA5, "R4 bad index write ignored");

    cfg_wr(8'h03, 8'h03);
    settle();
    chk("R3 disable drops all oe", 32'(gpio_oe_o), 32'h0);
    io_rd(16'hEB, 8'h00, "R3 disabled read");

    cfg_wr(8'h03, 8'h81);
    settle();
    chk("R10 re-enable resets configs", 32'(gpio_oe_o), 32'h0);
    io_wr(16'hE2, 8'h01);
    io_rd(16'hE3, 8'h3C, "R2 R10 pair 1 input read");

    repeat (4) @(negedge clk_i);
    chk("scoreboard drained", 32'(exp_q.size()), 32'h0);
    finish_run();
  end

endmodule